// File: doc/BRIEF.md
# Programmable Fill-Threshold Flag Unit

This unit sits beside a FIFO's storage and turns the FIFO's current word count into three status flags: almost empty, almost full and half full. The almost-empty and almost-full thresholds live in two offset registers. Master reset loads both registers with one of eight preset values. After reset, software or a neighbouring controller can reprogram them either one bit at a time through a serial input or a whole word at a time from a 36-bit bus. The programming method is fixed at master reset. Both registers can be read back over a 36-bit output bus.

The parallel load bus behaves as a stream with no back-pressure. A beat is valid when `wr_en` and `ld` are both high on a `wclk` edge, and the unit accepts every beat. The read-back path is also a stream. A request is `rd_en` with `ld` on a `rclk` edge. The answer appears with `dout_valid` for exactly one cycle and has no ready signal. The consumer must take the answer in that cycle.

The unit samples `ld`, `fsel`, `pfm` and `ipar` as configuration while `mrst_n` is low. Partial reset (`prs_n`) returns the load and read-back sequencing to their start but keeps the offsets and the configuration.

Top module: `pflag_unit`

## Requirements
- R1: `almost_empty` is 1 exactly when `fill` is less than the empty-side offset.
- R2: `almost_full` is 1 exactly when DEPTH minus `fill` is less than or equal to the full-side offset.
- R3: `half_full` is 1 exactly when `fill` is greater than DEPTH/2.
- R4: While `mrst_n` is low, the index idx = {ld, fsel[1], fsel[0]} loads both offsets with 2^(idx+3)-1 (idx 0..7 gives 7, 15, 31, 63, 127, 255, 511, 1023). In the same reset, `ld`=1 selects serial programming and `ld`=0 selects parallel programming.
- R5: In parallel mode, each `wclk` edge with `wr_en` and `ld` high loads one offset from `din`. Loads alternate: empty-side offset first, then full-side, then empty-side again.
- R6: With `ipar`=1 at master reset, din bits 8, 17, 26 and 35 are skipped, so payload bit i comes from din bit i + i/8. With `ipar`=0, the payload is din[31:0] and din[35:32] are ignored. The offset is the low OFF_W payload bits.
- R7: In serial mode, each `wclk` edge with `sen` and `ld` high shifts `si` into a 2*OFF_W chain. After 2*OFF_W shifts, the first bit sent is the LSB of the empty-side offset and the last bit sent is the MSB of the full-side offset. Parallel strobes are ignored in serial mode.
- R8: A read-back request on a `rclk` edge makes `dout` equal to the offset, zero-extended, with `dout_valid`=1 on the following cycle. Requests alternate: empty-side offset first, then full-side. Otherwise `dout_valid` is 0 and `dout` holds its value. After reset `dout` is 0.
- R9: Partial reset keeps both offsets and the programming mode. It restarts both the load order and the read-back order at the empty-side offset.
- R10: With `pfm`=1 at master reset, `almost_empty` is a register updated on `rclk` and `almost_full` a register updated on `wclk`, each one edge after `fill` changes. With `pfm`=0, both flags follow `fill` without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prs_n | input | 1 | Partial reset, active low, synchronous |
| fsel | input | 2 | Default-offset select, sampled in master reset |
| pfm | input | 1 | 1 = registered flags, sampled in master reset |
| ipar | input | 1 | 1 = skip parity bits on parallel load, sampled in master reset |
| ld | input | 1 | Offset access qualifier; configuration bit in master reset |
| wr_en | input | 1 | Parallel load strobe (valid) |
| sen | input | 1 | Serial shift enable |
| si | input | 1 | Serial data bit |
| din | input | 36 | Parallel offset data |
| rd_en | input | 1 | Read-back request |
| fill | input | CNT_W | FIFO word count |
| dout | output | 36 | Read-back data |
| dout_valid | output | 1 | Read-back data valid for one cycle |
| almost_empty | output | 1 | Almost-empty flag |
| almost_full | output | 1 | Almost-full flag |
| half_full | output | 1 | Half-full flag |

## Verification
Timing differs by result:
- Asynchronous-mode flags and `half_full` settle in the same cycle `fill` changes, so the bench checks them 1 ns after driving.
- Registered flags move on the next clock edge. The bench checks them twice: once before that edge, to see the old value, and once on the following falling edge.
- Offset loads take effect at the strobe's edge.
- Read-back answers are due one edge after the request. A monitor compares them on each falling edge where `dout_valid` is high, against a queue filled at request time.

// File: rtl/pflag_pkg.sv
package pflag_pkg;
  localparam int BUS_W  = 36;
  localparam int PAY_W  = 32;
  localparam int LANE_W = 9;

  // preset threshold for a 3-bit reset index: 2^(idx+3)-1
  function automatic logic [31:0] preset_offset(input logic [2:0] idx);
    return (32'd8 << idx) - 32'd1;
  endfunction

  // gather offset payload bits from the parallel bus
  function automatic logic [PAY_W-1:0] gather_payload(input logic [BUS_W-1:0] d,
                                                      input logic skip_par);
    logic [PAY_W-1:0] p;
    p = d[PAY_W-1:0];
    if (skip_par) begin
      for (int lane = 0; lane < 4; lane++)
        p[lane*8 +: 8] = d[lane*LANE_W +: 8];
    end
    return p;
  endfunction
endpackage

// File: rtl/pflag_offsets.sv
module pflag_offsets
  import pflag_pkg::*;
#(
  parameter int OFF_W = 10
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prs_n,
  input  logic [1:0]       fsel,
  input  logic             pfm,
  input  logic             ipar,
  input  logic             ld,
  input  logic             wr_en,
  input  logic             sen,
  input  logic             si,
  input  logic [BUS_W-1:0] din,
  output logic [OFF_W-1:0] off_e,
  output logic [OFF_W-1:0] off_f,
  output logic             cfg_sync
);
  localparam int CHAIN_W = 2 * OFF_W;

  logic             cfg_serial;
  logic             cfg_ipar;
  logic             wsel;
  logic [31:0]      preset_full;
  logic [OFF_W-1:0] preset_now;
  logic [PAY_W-1:0] payload;
  logic [CHAIN_W-1:0] chain_next;
  logic             spare_bits;

  always_comb begin
    preset_full = preset_offset({ld, fsel});
    preset_now  = preset_full[OFF_W-1:0];
    payload     = gather_payload(din, cfg_ipar);
    chain_next  = {si, off_f, off_e[OFF_W-1:1]};
  end

  assign spare_bits = ^{preset_full[31:OFF_W], payload[PAY_W-1:OFF_W], din[35:32]};

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      cfg_serial <= ld;
      cfg_sync   <= pfm;
      cfg_ipar   <= ipar;
      off_e      <= preset_now;
      off_f      <= preset_now;
      wsel       <= 1'b0;
    end else if (!prs_n) begin
      wsel <= 1'b0;
    end else if (cfg_serial) begin
      if (sen && ld) begin
        off_e <= chain_next[OFF_W-1:0];
        off_f <= chain_next[CHAIN_W-1:OFF_W];
      end
    end else if (wr_en && ld) begin
      if (wsel) off_f <= payload[OFF_W-1:0];
      else      off_e <= payload[OFF_W-1:0];
      wsel <= ~wsel;
    end
  end

  assert_preset_R4: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(mrst_n) |-> (off_e == $past(preset_now)) && (off_f == $past(preset_now)));

  assert_prs_keeps_R9: assert property (@(posedge clk) disable iff (!mrst_n)
    !prs_n |=> $stable(off_e) && $stable(off_f));

  assert_serial_ignores_par_R7: assert property (@(posedge clk) disable iff (!mrst_n)
    (cfg_serial && !(sen && ld)) |=> $stable(off_e) && $stable(off_f));

  assert_par_idle_R5: assert property (@(posedge clk) disable iff (!mrst_n)
    (!cfg_serial && !(wr_en && ld)) |=> $stable(off_e) && $stable(off_f));
endmodule

// File: rtl/pflag_thresh.sv
module pflag_thresh #(
  parameter int DEPTH = 1024,
  parameter int OFF_W = 10,
  parameter int CNT_W = 11
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             mrst_n,
  input  logic             prs_n,
  input  logic             cfg_sync,
  input  logic [CNT_W-1:0] fill,
  input  logic [OFF_W-1:0] off_e,
  input  logic [OFF_W-1:0] off_f,
  output logic             almost_empty,
  output logic             almost_full,
  output logic             half_full
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(DEPTH / 2);

  logic [CNT_W-1:0] free_cnt;
  logic [CNT_W-1:0] e_ext, f_ext;
  logic ae_now, af_now, ae_q, af_q;

  always_comb begin
    e_ext    = {{(CNT_W-OFF_W){1'b0}}, off_e};
    f_ext    = {{(CNT_W-OFF_W){1'b0}}, off_f};
    free_cnt = DEPTH_C - fill;
    ae_now   = fill < e_ext;
    af_now   = free_cnt <= f_ext;
  end

  always_ff @(posedge rclk) begin
    if (!mrst_n || !prs_n) ae_q <= 1'b1;
    else                   ae_q <= ae_now;
  end

  always_ff @(posedge wclk) begin
    if (!mrst_n || !prs_n) af_q <= 1'b0;
    else                   af_q <= af_now;
  end

  assign almost_empty = cfg_sync ? ae_q : ae_now;
  assign almost_full  = cfg_sync ? af_q : af_now;
  assign half_full    = fill > HALF_C;

  assert_sync_ae_R10: assert property (@(posedge rclk) disable iff (!mrst_n || !prs_n)
    cfg_sync |=> almost_empty == $past(ae_now));

  assert_sync_af_R10: assert property (@(posedge wclk) disable iff (!mrst_n || !prs_n)
    cfg_sync |=> almost_full == $past(af_now));

  assert_hf_vs_ae_R1: assert property (@(posedge rclk) disable iff (!mrst_n)
    (!cfg_sync && half_full && (e_ext <= HALF_C)) |-> !almost_empty);
endmodule

// File: rtl/pflag_readback.sv
module pflag_readback
  import pflag_pkg::*;
#(
  parameter int OFF_W = 10
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prs_n,
  input  logic             rd_en,
  input  logic             ld,
  input  logic [OFF_W-1:0] off_e,
  input  logic [OFF_W-1:0] off_f,
  output logic [BUS_W-1:0] dout,
  output logic             dout_valid
);
  logic rsel;

  always_ff @(posedge clk) begin
    if (!mrst_n || !prs_n) begin
      dout       <= '0;
      dout_valid <= 1'b0;
      rsel       <= 1'b0;
    end else if (rd_en && ld) begin
      dout       <= {{(BUS_W-OFF_W){1'b0}}, (rsel ? off_f : off_e)};
      dout_valid <= 1'b1;
      rsel       <= ~rsel;
    end else begin
      dout_valid <= 1'b0;
    end
  end

  assert_rb_valid_R8: assert property (@(posedge clk) disable iff (!mrst_n || !prs_n)
    (rd_en && ld) |=> dout_valid);

  assert_rb_idle_R8: assert property (@(posedge clk) disable iff (!mrst_n || !prs_n)
    !(rd_en && ld) |=> !dout_valid && $stable(dout));
endmodule

// File: rtl/pflag_unit.sv
module pflag_unit
  import pflag_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int OFF_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             mrst_n,
  input  logic             prs_n,
  input  logic [1:0]       fsel,
  input  logic             pfm,
  input  logic             ipar,
  input  logic             ld,
  input  logic             wr_en,
  input  logic             sen,
  input  logic             si,
  input  logic [35:0]      din,
  input  logic             rd_en,
  input  logic [CNT_W-1:0] fill,
  output logic [35:0]      dout,
  output logic             dout_valid,
  output logic             almost_empty,
  output logic             almost_full,
  output logic             half_full
);
  logic [OFF_W-1:0] off_e, off_f;
  logic             cfg_sync;

  pflag_offsets #(.OFF_W(OFF_W)) u_offsets (
    .clk(wclk), .mrst_n(mrst_n), .prs_n(prs_n), .fsel(fsel), .pfm(pfm),
    .ipar(ipar), .ld(ld), .wr_en(wr_en), .sen(sen), .si(si), .din(din),
    .off_e(off_e), .off_f(off_f), .cfg_sync(cfg_sync)
  );

  pflag_thresh #(.DEPTH(DEPTH), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_thresh (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prs_n(prs_n),
    .cfg_sync(cfg_sync), .fill(fill), .off_e(off_e), .off_f(off_f),
    .almost_empty(almost_empty), .almost_full(almost_full), .half_full(half_full)
  );

  pflag_readback #(.OFF_W(OFF_W)) u_readback (
    .clk(rclk), .mrst_n(mrst_n), .prs_n(prs_n), .rd_en(rd_en), .ld(ld),
    .off_e(off_e), .off_f(off_f), .dout(dout), .dout_valid(dout_valid)
  );
endmodule

// File: tb/pflag_unit_tb.sv
module pflag_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;
  localparam int OFF_W = 10;
  localparam int CNT_W = 11;

  logic clk = 1'b0;
  logic mrst_n = 1'b0, prs_n = 1'b1;
  logic [1:0] fsel = '0;
  logic pfm = 1'b0, ipar = 1'b0, ld = 1'b0, wr_en = 1'b0, sen = 1'b0, si = 1'b0, rd_en = 1'b0;
  logic [35:0] din = '0;
  logic [CNT_W-1:0] fill = '0;
  logic [35:0] dout;
  logic dout_valid, almost_empty, almost_full, half_full;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [OFF_W-1:0] e_m, f_m;
  bit wsel_m, rsel_m, serial_m, ipar_m;
  logic [OFF_W-1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pflag_unit #(.DEPTH(DEPTH)) u_dut (
    .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .prs_n(prs_n), .fsel(fsel), .pfm(pfm),
    .ipar(ipar), .ld(ld), .wr_en(wr_en), .sen(sen), .si(si), .din(din), .rd_en(rd_en),
    .fill(fill), .dout(dout), .dout_valid(dout_valid), .almost_empty(almost_empty),
    .almost_full(almost_full), .half_full(half_full)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: scoreboard for read-back answers
  always @(negedge clk) begin
    if (dout_valid) begin
      if (exp_q.size() == 0) chk(0, "R8 unexpected valid", dout, 0);
      else begin
        logic [OFF_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(dout == {26'd0, e}, t, dout, e);
      end
    end
  end

  task automatic mreset(input bit l, input logic [1:0] fs, input bit p, input bit ip);
    logic [31:0] pre;
    @(negedge clk);
    mrst_n = 0; ld = l; fsel = fs; pfm = p; ipar = ip; fill = '0;
    @(negedge clk); @(negedge clk);
    mrst_n = 1; ld = 0;
    pre = (32'd1 << ({l, fs} + 3)) - 1;
    e_m = pre[OFF_W-1:0]; f_m = pre[OFF_W-1:0];
    wsel_m = 0; rsel_m = 0; serial_m = l; ipar_m = ip;
  endtask

  task automatic prst();
    @(negedge clk); prs_n = 0;
    @(negedge clk); prs_n = 1;
    wsel_m = 0; rsel_m = 0;
  endtask

  task automatic rb(input string tag);
    @(negedge clk); ld = 1; rd_en = 1;
    exp_q.push_back(rsel_m ? f_m : e_m); tag_q.push_back(tag);
    rsel_m = !rsel_m;
    @(negedge clk); ld = 0; rd_en = 0;
  endtask

  task automatic pload(input logic [35:0] d);
    logic [OFF_W-1:0] v;
    int j;
    @(negedge clk); ld = 1; wr_en = 1; din = d;
    @(negedge clk); ld = 0; wr_en = 0;
    j = 0; v = '0;
    for (int b = 0; b < 36 && j < OFF_W; b++) begin
      if (ipar_m && (b % 9 == 8)) continue;
      v[j] = d[b]; j++;
    end
    if (!serial_m) begin
      if (wsel_m) f_m = v; else e_m = v;
      wsel_m = !wsel_m;
    end
  endtask

  task automatic sshift(input logic [2*OFF_W-1:0] val);
    for (int i = 0; i < 2*OFF_W; i++) begin
      @(negedge clk); sen = 1; ld = 1; si = val[i];
    end
    @(negedge clk); sen = 0; ld = 0;
    if (serial_m) begin e_m = val[OFF_W-1:0]; f_m = val[2*OFF_W-1:OFF_W]; end
  endtask

  task automatic setfill(input int v); @(negedge clk); fill = CNT_W'(v); #1; endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // A: parallel, async, no parity skip, preset idx 1 -> 15
    mreset(0, 2'b01, 0, 0);
    #1;
    chk(almost_empty == 1, "R1 reset ae", almost_empty, 1);
    chk(almost_full == 0, "R2 reset af", almost_full, 0);
    chk(half_full == 0, "R3 reset hf", half_full, 0);
    chk(dout == 0 && dout_valid == 0, "R8 reset dout", dout, 0);
    rb("R4 preset e"); rb("R4 preset f");
    setfill(14);   chk(almost_empty == 1, "R1 fill14", almost_empty, 1);
    setfill(15);   chk(almost_empty == 0, "R1 fill15", almost_empty, 0);
    setfill(1009); chk(almost_full == 1, "R2 free15", almost_full, 1);
    setfill(1008); chk(almost_full == 0, "R2 free16", almost_full, 0);
    setfill(512);  chk(half_full == 0, "R3 fill512", half_full, 0);
    setfill(513);  chk(half_full == 1, "R3 fill513", half_full, 1);
    pload(36'hF_0000_00C8); pload(36'd300);
    rb("R5 par e"); rb("R5 par f");
    setfill(199);  chk(almost_empty == 1, "R6 e200 fill199", almost_empty, 1);
    setfill(200);  chk(almost_empty == 0, "R6 e200 fill200", almost_empty, 0);
    pload(36'd400);
    rb("R5 wrap e"); rb("R5 wrap f");
    // partial reset
    prst();
    rb("R9 kept e"); rb("R9 kept f");
    pload(36'd50);
    rb("R9 order restart e");
    // B: parallel, sync, parity skip, preset idx 3 -> 63
    mreset(0, 2'b11, 1, 1);
    rb("R4 preset63");
    pload(36'h8_0000_0305);
    rb("R6 skip parity e");
    setfill(300);
    chk(almost_empty == 1, "R10 ae before edge", almost_empty, 1);
    @(negedge clk);
    chk(almost_empty == 0, "R10 ae after edge", almost_empty, 0);
    setfill(1000);
    chk(almost_full == 0, "R10 af before edge", almost_full, 0);
    @(negedge clk);
    chk(almost_full == 1, "R10 af after edge", almost_full, 1);
    // C: serial, async, preset idx 4 -> 127
    mreset(1, 2'b00, 0, 0);
    rb("R4 serial preset e"); rb("R4 serial preset f");
    pload(36'd5);
    rb("R7 par ignored e");
    sshift({10'd99, 10'd37});
    rb("R7 serial f"); rb("R7 serial e");
    setfill(36); chk(almost_empty == 1, "R7 fill36", almost_empty, 1);
    setfill(37); chk(almost_empty == 0, "R7 fill37", almost_empty, 0);
    @(negedge clk); @(negedge clk);
    chk(exp_q.size() == 0, "R8 answers outstanding", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule